// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Sequencer

This block owns the refresh side of an asynchronous DRAM whose rows are counted inside the device. Once reset is released it waits out the supply settling delay. It then runs a fixed number of CAS-before-RAS initialisation cycles. After that it raises a refresh request at a steady rate, so that every row is refreshed within the retention window without the block ever producing an address. Because the device advances its own row pointer on every CAS-before-RAS cycle, only the two strobes are sequenced. Address, write-enable, output-enable and the data pins stay with the access controller and are don't-care during these cycles.

The block shares the strobes with an access controller through a three-signal handshake. The sequencer raises a request. The controller grants the strobes when it is between accesses. The sequencer pulses a completion flag in the last cycle it drives them. Refreshes that fall due while the grant is delayed are counted, up to a parameter limit, and served back to back. On command the block can also put the device into self-refresh. It holds both strobes low past the entry threshold, keeps RAS low while the device refreshes itself, and on an exit command raises RAS and enforces the longer self-refresh precharge.

Every delay is given in nanoseconds and turned into clock cycles at elaboration time from the clock period parameter. A conversion rounds up and gives at least one cycle. The self-refresh hold is rounded to one cycle beyond the threshold, since the threshold must be exceeded.

Top module: `dram_refresh_seq`

## Requirements
- R1: While reset is asserted, ras_n and cas_n are 1, and ref_req, ref_done, bus_own, init_done and in_self are 0.
- R2: ref_req first rises exactly PWRUP_CYC + 2 rising clock edges after rst_n is released. The two extra edges are the reset synchroniser.
- R3: Every cycle the block drives starts with cas_n low and ras_n high for CSR_CYC clocks, followed by both strobes low. ras_n never falls while cas_n is high.
- R4: A normal refresh or initialisation cycle holds both strobes low for CHR_CYC clocks. It then holds ras_n low with cas_n high for RASH_CYC = max(RAS_CYC - CHR_CYC, 1) clocks, and then both strobes high for RP_CYC clocks. ref_done is 1 in the last of those clocks only, and bus_own is 0 in the following clock.
- R5: Exactly INIT_CYCLES initialisation cycles are run before init_done goes to 1. init_done rises in the clock after the last initialisation ref_done. A self_enter pulse given before init_done is 1 has no effect.
- R6: The strobes move only after a grant. bus_own rises only when ref_gnt was 1 at the starting edge, and whenever bus_own is 0 both strobes are 1.
- R7: When every request is granted at once, successive refresh requests rise exactly REFI_CYC clocks apart.
- R8: The interval counter keeps running while a request waits for its grant. Owed refreshes accumulate up to MAX_OWED and are served back to back while ref_gnt stays 1.
- R9: A self_enter pulse after init_done raises a request. That request is served ahead of owed refreshes. Its cycle holds cas_n low alone for CSR_CYC clocks, then both strobes low for SELF_CYC clocks, after which in_self becomes 1.
- R10: While in_self is 1, ras_n stays 0 and ref_done stays 0 until self_exit is sampled as 1.
- R11: In the clock after self_exit is sampled during self-refresh, ras_n and cas_n are 1 and in_self is 0. Both strobes then stay high for RPS_CYC clocks in total, and ref_done is 1 in the last of them.
- R12: A self_exit pulse outside self-refresh has no effect: no request, and no strobe movement.
- R13: Leaving self-refresh clears the owed count and restarts the interval. No refresh request appears for REFI_CYC - 2 clocks after the exit ref_done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through a synchroniser |
| ref_gnt | input | 1 | Strobe grant from the access controller, held until ref_done |
| self_enter | input | 1 | Pulse: request entry into self-refresh |
| self_exit | input | 1 | Pulse: leave self-refresh |
| ref_req | output | 1 | Request for the strobes (initialisation, refresh or self-refresh entry pending) |
| ref_done | output | 1 | One-clock flag in the final clock the block drives the strobes |
| bus_own | output | 1 | The block is driving ras_n and cas_n |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| init_done | output | 1 | All initialisation cycles have completed |
| in_self | output | 1 | The device is being held in self-refresh |

## Verification
A corrupted phase counter or state register shows up within a single refresh cycle as a wrong number of clocks in one strobe phase, or as RAS falling without CAS already low. The bench counts each phase of every granted cycle. A wrong owed count or interval counter shows only on the scale of REFI_CYC: as a changed gap between requests, or as the wrong number of back-to-back cycles after a long stall. A self-refresh fault appears either at entry, as a wrong count of the both-low hold, or at exit, as a wrong precharge length or a request that appears before the restarted interval.

// File: rtl/dram_rfsh_pkg.sv
package dram_rfsh_pkg;

  typedef enum logic [2:0] {
    ST_PWRUP,
    ST_IDLE,
    ST_CSR,
    ST_CHR,
    ST_RASH,
    ST_SENTRY,
    ST_SELF,
    ST_PRE
  } seq_state_e;

  typedef enum logic [1:0] {
    K_INIT,
    K_REFR,
    K_SELF
  } cyc_kind_e;

  // At least the given time, at least one cycle.
  function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned clk_ps);
    longint unsigned p;
    p = (longint'(ns) * 1000 + longint'(clk_ps) - 1) / longint'(clk_ps);
    if (p == 0) p = 1;
    return int'(p);
  endfunction

  // Strictly longer than the given time.
  function automatic int unsigned ns_to_cyc_gt(input int unsigned ns, input int unsigned clk_ps);
    longint unsigned p;
    p = (longint'(ns) * 1000) / longint'(clk_ps) + 1;
    return int'(p);
  endfunction

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/rfsh_phase_cnt.sv
module rfsh_phase_cnt #(
  parameter int unsigned CW      = 8,
  parameter int unsigned RST_VAL = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          zero
);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  assign zero   = (cnt_q == '0);
  assign cnt_en = load || !zero;

  always_comb begin
    if (load) cnt_d = load_val;
    else      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= CW'(RST_VAL);
    else if (cnt_en) cnt_q <= cnt_d;
  end

endmodule

// File: rtl/rfsh_interval_timer.sv
module rfsh_interval_timer #(
  parameter int unsigned REFI_CYC = 1950,
  parameter int unsigned MAX_OWED = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic clear,
  input  logic take,
  output logic owed_nz
);

  localparam int unsigned TW = (REFI_CYC > 1) ? $clog2(REFI_CYC) : 1;
  localparam int unsigned OW = $clog2(MAX_OWED + 1);

  logic [TW-1:0] cnt_q;
  logic [TW-1:0] cnt_d;
  logic          cnt_en;
  logic          tick;

  assign tick   = run && (cnt_q == TW'(REFI_CYC - 1));
  assign cnt_en = clear || run;

  always_comb begin
    if (clear || tick) cnt_d = '0;
    else               cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  logic [OW-1:0] owed_q;

  generate
    if (MAX_OWED == 1) begin : g_flag
      logic flag_d;
      always_comb begin
        if (clear)     flag_d = 1'b0;
        else if (tick) flag_d = 1'b1;
        else if (take) flag_d = 1'b0;
        else           flag_d = owed_q[0];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) owed_q <= '0;
        else        owed_q <= flag_d;
      end
    end else begin : g_count
      logic [OW-1:0] owed_d;
      logic          at_max;
      assign at_max = (owed_q == OW'(MAX_OWED));
      always_comb begin
        owed_d = owed_q;
        if (clear)                        owed_d = '0;
        else if (tick && !take && !at_max) owed_d = owed_q + 1'b1;
        else if (take && !tick)           owed_d = owed_q - 1'b1;
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) owed_q <= '0;
        else        owed_q <= owed_d;
      end
    end
  endgenerate

  assign owed_nz = (owed_q != '0);

  assert_owed_sat_R8: assert property (@(posedge clk) disable iff (!rst_n)
    owed_q <= OW'(MAX_OWED));

  assert_clear_owed_R13: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (owed_q == '0));

endmodule

// File: rtl/rfsh_strobe_fsm.sv
module rfsh_strobe_fsm
  import dram_rfsh_pkg::*;
#(
  parameter int unsigned CW          = 8,
  parameter int unsigned INIT_CYCLES = 8,
  parameter int unsigned CSR_CYC     = 1,
  parameter int unsigned CHR_CYC     = 2,
  parameter int unsigned RASH_CYC    = 5,
  parameter int unsigned RP_CYC      = 4,
  parameter int unsigned RPS_CYC     = 11,
  parameter int unsigned SELF_CYC    = 12501
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ref_gnt,
  input  logic          self_enter,
  input  logic          self_exit,
  input  logic          cnt_zero,
  input  logic          owed_nz,
  output logic          cnt_load,
  output logic [CW-1:0] cnt_val,
  output logic          take,
  output logic          tmr_clear,
  output logic          init_done,
  output logic          ref_req,
  output logic          ref_done,
  output logic          bus_own,
  output logic          ras_n,
  output logic          cas_n,
  output logic          in_self
);

  localparam int unsigned IW = $clog2(INIT_CYCLES + 1);

  seq_state_e    state_q, state_d;
  cyc_kind_e     kind_q, kind_d;
  logic [IW-1:0] init_left_q, init_left_d;
  logic          self_pend_q, self_pend_d;
  logic          ras_q, cas_q, own_q;
  logic          ras_d, cas_d, own_d;
  logic          self_active;

  assign self_active = (kind_q == K_SELF) && (state_q != ST_IDLE);
  assign init_done   = (init_left_q == '0);
  assign ref_req     = (state_q == ST_IDLE) &&
                       ((init_left_q != '0) || self_pend_q || owed_nz);
  assign ref_done    = (state_q == ST_PRE) && cnt_zero;
  assign in_self     = (state_q == ST_SELF);
  assign tmr_clear   = self_active;

  always_comb begin
    state_d     = state_q;
    kind_d      = kind_q;
    init_left_d = init_left_q;
    self_pend_d = self_pend_q;
    cnt_load    = 1'b0;
    cnt_val     = '0;
    take        = 1'b0;

    if (self_enter && init_done && !self_active) self_pend_d = 1'b1;

    case (state_q)
      ST_PWRUP: begin
        if (cnt_zero) state_d = ST_IDLE;
      end
      ST_IDLE: begin
        if (ref_req && ref_gnt) begin
          state_d  = ST_CSR;
          cnt_load = 1'b1;
          cnt_val  = CW'(CSR_CYC - 1);
          if (init_left_q != '0) begin
            kind_d = K_INIT;
          end else if (self_pend_q) begin
            kind_d      = K_SELF;
            self_pend_d = 1'b0;
          end else begin
            kind_d = K_REFR;
            take   = 1'b1;
          end
        end
      end
      ST_CSR: begin
        if (cnt_zero) begin
          cnt_load = 1'b1;
          if (kind_q == K_SELF) begin
            state_d = ST_SENTRY;
            cnt_val = CW'(SELF_CYC - 1);
          end else begin
            state_d = ST_CHR;
            cnt_val = CW'(CHR_CYC - 1);
          end
        end
      end
      ST_CHR: begin
        if (cnt_zero) begin
          state_d  = ST_RASH;
          cnt_load = 1'b1;
          cnt_val  = CW'(RASH_CYC - 1);
        end
      end
      ST_RASH: begin
        if (cnt_zero) begin
          state_d  = ST_PRE;
          cnt_load = 1'b1;
          cnt_val  = CW'(RP_CYC - 1);
        end
      end
      ST_SENTRY: begin
        if (cnt_zero) state_d = ST_SELF;
      end
      ST_SELF: begin
        if (self_exit) begin
          state_d  = ST_PRE;
          cnt_load = 1'b1;
          cnt_val  = CW'(RPS_CYC - 1);
        end
      end
      ST_PRE: begin
        if (cnt_zero) begin
          state_d = ST_IDLE;
          if (kind_q == K_INIT) init_left_d = init_left_q - 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    ras_d = !(state_d inside {ST_CHR, ST_RASH, ST_SENTRY, ST_SELF});
    cas_d = !(state_d inside {ST_CSR, ST_CHR, ST_SENTRY, ST_SELF});
    own_d = !(state_d inside {ST_PWRUP, ST_IDLE});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_PWRUP;
      kind_q      <= K_INIT;
      init_left_q <= IW'(INIT_CYCLES);
      self_pend_q <= 1'b0;
      ras_q       <= 1'b1;
      cas_q       <= 1'b1;
      own_q       <= 1'b0;
    end else begin
      state_q     <= state_d;
      kind_q      <= kind_d;
      init_left_q <= init_left_d;
      self_pend_q <= self_pend_d;
      ras_q       <= ras_d;
      cas_q       <= cas_d;
      own_q       <= own_d;
    end
  end

  assign ras_n   = ras_q;
  assign cas_n   = cas_q;
  assign bus_own = own_q;

  assert_cbr_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> (!cas_n && $past(!cas_n)));

  assert_done_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ref_done |=> !bus_own);

  assert_grant_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_own) |-> $past(ref_gnt));

  assert_init_after_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(init_done) |-> $past(ref_done));

  assert_self_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    in_self |-> (!ras_n && !ref_done));

endmodule

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq
  import dram_rfsh_pkg::*;
#(
  parameter int unsigned CLK_PS      = 8000,
  parameter int unsigned T_PWRUP_NS  = 200000,
  parameter int unsigned T_REFI_NS   = 15600,
  parameter int unsigned T_SELF_NS   = 100000,
  parameter int unsigned T_CSR_NS    = 5,
  parameter int unsigned T_CHR_NS    = 10,
  parameter int unsigned T_RAS_NS    = 50,
  parameter int unsigned T_RP_NS     = 30,
  parameter int unsigned T_RPS_NS    = 84,
  parameter int unsigned INIT_CYCLES = 8,
  parameter int unsigned MAX_OWED    = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_gnt,
  input  logic self_enter,
  input  logic self_exit,
  output logic ref_req,
  output logic ref_done,
  output logic bus_own,
  output logic ras_n,
  output logic cas_n,
  output logic init_done,
  output logic in_self
);

  localparam int unsigned PWRUP_CYC = ns_to_cyc(T_PWRUP_NS, CLK_PS);
  localparam int unsigned REFI_CYC  = ns_to_cyc(T_REFI_NS, CLK_PS);
  localparam int unsigned SELF_CYC  = ns_to_cyc_gt(T_SELF_NS, CLK_PS);
  localparam int unsigned CSR_CYC   = ns_to_cyc(T_CSR_NS, CLK_PS);
  localparam int unsigned CHR_CYC   = ns_to_cyc(T_CHR_NS, CLK_PS);
  localparam int unsigned RAS_CYC   = ns_to_cyc(T_RAS_NS, CLK_PS);
  localparam int unsigned RP_CYC    = ns_to_cyc(T_RP_NS, CLK_PS);
  localparam int unsigned RPS_CYC   = ns_to_cyc(T_RPS_NS, CLK_PS);
  localparam int unsigned RASH_CYC  = (RAS_CYC > CHR_CYC + 1) ? (RAS_CYC - CHR_CYC) : 1;
  localparam int unsigned MAX_CYC   = max_u(max_u(PWRUP_CYC, SELF_CYC),
                                            max_u(max_u(CSR_CYC, CHR_CYC),
                                                  max_u(max_u(RASH_CYC, RP_CYC), RPS_CYC)));
  localparam int unsigned CW        = $clog2(MAX_CYC + 1);

  // reset: asynchronous assertion, synchronous release
  logic rst_s1_q, rst_s2_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_s2_q <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_s2_q <= rst_s1_q;
    end
  end

  logic          rst_i_n;
  logic          cnt_load;
  logic [CW-1:0] cnt_val;
  logic          cnt_zero;
  logic          take;
  logic          tmr_clear;
  logic          owed_nz;

  assign rst_i_n = rst_s2_q;

  rfsh_phase_cnt #(
    .CW      (CW),
    .RST_VAL (PWRUP_CYC - 1)
  ) phase_i (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .load     (cnt_load),
    .load_val (cnt_val),
    .zero     (cnt_zero)
  );

  rfsh_interval_timer #(
    .REFI_CYC (REFI_CYC),
    .MAX_OWED (MAX_OWED)
  ) interval_i (
    .clk     (clk),
    .rst_n   (rst_i_n),
    .run     (init_done),
    .clear   (tmr_clear),
    .take    (take),
    .owed_nz (owed_nz)
  );

  rfsh_strobe_fsm #(
    .CW          (CW),
    .INIT_CYCLES (INIT_CYCLES),
    .CSR_CYC     (CSR_CYC),
    .CHR_CYC     (CHR_CYC),
    .RASH_CYC    (RASH_CYC),
    .RP_CYC      (RP_CYC),
    .RPS_CYC     (RPS_CYC),
    .SELF_CYC    (SELF_CYC)
  ) fsm_i (
    .clk        (clk),
    .rst_n      (rst_i_n),
    .ref_gnt    (ref_gnt),
    .self_enter (self_enter),
    .self_exit  (self_exit),
    .cnt_zero   (cnt_zero),
    .owed_nz    (owed_nz),
    .cnt_load   (cnt_load),
    .cnt_val    (cnt_val),
    .take       (take),
    .tmr_clear  (tmr_clear),
    .init_done  (init_done),
    .ref_req    (ref_req),
    .ref_done   (ref_done),
    .bus_own    (bus_own),
    .ras_n      (ras_n),
    .cas_n      (cas_n),
    .in_self    (in_self)
  );

  assert_idle_strobes_R6: assert property (@(posedge clk) disable iff (!rst_i_n)
    !bus_own |-> (ras_n && cas_n));

endmodule

// File: tb/dram_refresh_seq_tb_top.sv
`timescale 1ns/1ps
module dram_refresh_seq_tb_top;

  localparam int CLK_PS     = 8000;
  localparam int PWRUP_NS   = 400;
  localparam int REFI_NS    = 800;
  localparam int SELF_NS    = 240;
  localparam int INIT_N     = 8;
  localparam int OWED_MAX   = 3;

  // expected cycle counts, rounded up (self hold: strictly longer)
  localparam int PWRUP_CYC = (PWRUP_NS * 1000 + CLK_PS - 1) / CLK_PS;
  localparam int REFI_CYC  = (REFI_NS * 1000 + CLK_PS - 1) / CLK_PS;
  localparam int SELF_CYC  = (SELF_NS * 1000) / CLK_PS + 1;
  localparam int CSR_CYC   = (5 * 1000 + CLK_PS - 1) / CLK_PS;
  localparam int CHR_CYC   = (10 * 1000 + CLK_PS - 1) / CLK_PS;
  localparam int RAS_CYC   = (50 * 1000 + CLK_PS - 1) / CLK_PS;
  localparam int RP_CYC    = (30 * 1000 + CLK_PS - 1) / CLK_PS;
  localparam int RPS_CYC   = (84 * 1000 + CLK_PS - 1) / CLK_PS;
  localparam int RASH_CYC  = (RAS_CYC > CHR_CYC + 1) ? RAS_CYC - CHR_CYC : 1;

  logic clk, rst_n, ref_gnt, self_enter, self_exit;
  logic ref_req, ref_done, bus_own, ras_n, cas_n, init_done, in_self;

  dram_refresh_seq #(
    .CLK_PS      (CLK_PS),
    .T_PWRUP_NS  (PWRUP_NS),
    .T_REFI_NS   (REFI_NS),
    .T_SELF_NS   (SELF_NS),
    .T_CSR_NS    (5),
    .T_CHR_NS    (10),
    .T_RAS_NS    (50),
    .T_RP_NS     (30),
    .T_RPS_NS    (84),
    .INIT_CYCLES (INIT_N),
    .MAX_OWED    (OWED_MAX)
  ) dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .ref_gnt    (ref_gnt),
    .self_enter (self_enter),
    .self_exit  (self_exit),
    .ref_req    (ref_req),
    .ref_done   (ref_done),
    .bus_own    (bus_own),
    .ras_n      (ras_n),
    .cas_n      (cas_n),
    .init_done  (init_done),
    .in_self    (in_self)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int mon_err = 0;
  logic own_prev = 1'b0;

  task automatic chk_eq(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 40000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 40000);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  // R6 monitor: no strobe activity without ownership, no start without grant
  always @(negedge clk) begin
    if (rst_n) begin
      if (!bus_own && (!ras_n || !cas_n)) mon_err++;
      if (bus_own && !own_prev && !ref_gnt) mon_err++;
    end
    own_prev <= bus_own;
  end

  int n_csr, n_both, n_rash, n_pre, n_done;
  bit saw_self;

  task automatic run_grant(input int limit);
    n_csr = 0; n_both = 0; n_rash = 0; n_pre = 0; n_done = 0; saw_self = 0;
    ref_gnt = 1'b1;
    for (int i = 0; i < limit; i++) begin
      @(posedge clk); @(negedge clk);
      if (in_self) begin saw_self = 1; break; end
      if (!cas_n && ras_n)       n_csr++;
      else if (!cas_n && !ras_n) n_both++;
      else if (cas_n && !ras_n)  n_rash++;
      else                       n_pre++;
      if (ref_done) begin n_done++; break; end
    end
    if (!saw_self) ref_gnt = 1'b0;
  endtask

  task automatic wait_req(input int limit, output int at, output bit found);
    found = 0; at = 0;
    for (int i = 0; i < limit; i++) begin
      if (ref_req) begin found = 1; at = cyc; break; end
      @(posedge clk); @(negedge clk);
    end
  endtask

  task automatic check_normal_shape(input string tag);
    chk_eq({tag, " R3 cas-only clocks"}, n_csr, CSR_CYC);
    chk_eq({tag, " R4 both-low clocks"}, n_both, CHR_CYC);
    chk_eq({tag, " R4 ras-only clocks"}, n_rash, RASH_CYC);
    chk_eq({tag, " R4 precharge clocks"}, n_pre, RP_CYC);
    chk_eq({tag, " R4 done pulses"}, n_done, 1);
  endtask

  initial begin
    int n, t_prev, t_now, dones, bad;
    bit found;
    rst_n = 1'b0; ref_gnt = 1'b0; self_enter = 1'b0; self_exit = 1'b0;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk_eq("R1 ras_n", ras_n, 1);
    chk_eq("R1 cas_n", cas_n, 1);
    chk_eq("R1 outputs low", {ref_req, ref_done, bus_own, init_done, in_self}, 0);

    // R2 power-up delay; self_enter during power-up must be ignored (R5)
    rst_n = 1'b1;
    n = 0;
    for (int i = 0; i < 300; i++) begin
      @(posedge clk); n++; @(negedge clk);
      self_enter = (n == 10);
      if (ref_req) break;
    end
    self_enter = 1'b0;
    chk_eq("R2 power-up edges", n, PWRUP_CYC + 2);

    // R5 initialisation cycles
    for (int k = 0; k < INIT_N; k++) begin
      chk_eq("R5 init_done before last", init_done, 0);
      chk_eq("R5 request pending", ref_req, 1);
      run_grant(100);
      if (k == 0) check_normal_shape("init");
      else chk_eq("R4 init length", n_csr + n_both + n_rash + n_pre, CSR_CYC + CHR_CYC + RASH_CYC + RP_CYC);
      @(posedge clk); @(negedge clk);
    end
    chk_eq("R5 init_done after count", init_done, 1);
    chk_eq("R5 no extra init request", ref_req, 0);

    // first periodic refresh: normal shape, earlier self_enter ignored (R5)
    wait_req(300, t_prev, found);
    chk_eq("R7 first refresh request", found, 1);
    run_grant(100);
    check_normal_shape("refresh");

    // R7 request spacing with immediate grant
    for (int k = 0; k < 3; k++) begin
      wait_req(300, t_now, found);
      chk_eq("R7 request interval", t_now - t_prev, REFI_CYC);
      t_prev = t_now;
      run_grant(100);
    end

    // R8 owed refreshes under delayed grant: two owed
    repeat (250) @(negedge clk);
    chk_eq("R8 request while waiting", ref_req, 1);
    ref_gnt = 1'b1; dones = 0;
    repeat (30) begin @(posedge clk); @(negedge clk); if (ref_done) dones++; end
    ref_gnt = 1'b0;
    chk_eq("R8 two owed served", dones, 2);

    // R8 saturation at MAX_OWED
    repeat (420) @(negedge clk);
    ref_gnt = 1'b1; dones = 0;
    repeat (45) begin @(posedge clk); @(negedge clk); if (ref_done) dones++; end
    ref_gnt = 1'b0;
    chk_eq("R8 saturated owed served", dones, OWED_MAX);
    chk_eq("R8 queue drained", ref_req, 0);

    // R12 stray self_exit
    self_exit = 1'b1; @(posedge clk); @(negedge clk); self_exit = 1'b0;
    bad = 0;
    repeat (8) begin
      if (ref_req || !ras_n || !cas_n || in_self || bus_own) bad++;
      @(posedge clk); @(negedge clk);
    end
    chk_eq("R12 stray exit ignored", bad, 0);

    // R9 self-refresh entry
    self_enter = 1'b1; @(posedge clk); @(negedge clk); self_enter = 1'b0;
    wait_req(20, t_now, found);
    chk_eq("R9 self request", found, 1);
    run_grant(200);
    chk_eq("R9 reached self-refresh", saw_self, 1);
    chk_eq("R9 cas-only clocks", n_csr, CSR_CYC);
    chk_eq("R9 both-low hold", n_both, SELF_CYC);
    chk_eq("R9 no ras-only phase", n_rash, 0);

    // R10 hold in self-refresh
    bad = 0;
    repeat (20) begin
      if (ras_n || !in_self || ref_done) bad++;
      @(posedge clk); @(negedge clk);
    end
    chk_eq("R10 self hold", bad, 0);

    // R11 exit
    self_exit = 1'b1; @(posedge clk); @(negedge clk); self_exit = 1'b0;
    chk_eq("R11 ras_n after exit", ras_n, 1);
    chk_eq("R11 cas_n after exit", cas_n, 1);
    chk_eq("R11 in_self after exit", in_self, 0);
    n = 1;
    for (int i = 0; i < 50; i++) begin
      if (ref_done) break;
      @(posedge clk); @(negedge clk); n++;
    end
    chk_eq("R11 precharge clocks", n, RPS_CYC);
    ref_gnt = 1'b0;

    // R13 interval restarts after exit
    bad = 0;
    for (int i = 1; i <= REFI_CYC - 2; i++) begin
      @(posedge clk); @(negedge clk);
      if (ref_req) bad++;
    end
    chk_eq("R13 quiet after exit", bad, 0);
    wait_req(10, t_now, found);
    chk_eq("R13 request resumes", found, 1);
    run_grant(100);
    check_normal_shape("post-self");

    chk_eq("R6 strobe ownership", mon_err, 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule